// File: doc/BRIEF.md
# CPU Halt and Memory Dump Controller

This block gives a diagnostic path into a running 8-bit system built around a 6502-style bus. When a dump request arrives with a base address and a byte count, the block pulls the CPU ready line low. It treats the CPU as stopped only once a bus cycle has ended as a read, because the ready input of this CPU family is ignored during write cycles. It then takes the address lines and reads memory one byte at a time. Each byte goes out on a byte stream with a valid/ready handshake toward a serial transmitter.

Every access the block makes falls inside the phase-2 high window of the host bus cycle. The video controller keeps its share of the bus in the other phase. The block runs on a fast system clock and samples the phase-2 level and the CPU read/write line as inputs synchronous to that clock. A new byte is fetched only after the previous one has been accepted. When the last byte has been accepted, the ready line is released and the CPU resumes.

Top module: `halt_dump_ctrl`

## Requirements
- R1: While reset is active, and on leaving it, `cpu_rdy` is 1, `tx_valid` is 0 and `bus_oe` is 0.
- R2: In idle, a `req_start` pulse with a nonzero `req_len` drives `cpu_rdy` to 0 from the next clock, and `cpu_rdy` stays 0 until the dump ends. A request with `req_len` equal to 0 is ignored: `cpu_rdy` stays 1 and no byte is produced.
- R3: The halt takes effect only at a phase-2 falling edge (`phi2` going from 1 to 0 between two clocks) seen while `cpu_rw` is 1 (read) and `cpu_rdy` is 0. A falling edge that ends a write cycle (`cpu_rw` 0) does not count. `bus_oe` is never 1 before the halt has taken effect.
- R4: `bus_oe` is 1 only while `phi2` is 1, and then `bus_rw` is 1 (read). The address for byte n (counting from 0) is `req_base + n` modulo 2^AW.
- R5: Exactly `req_len` bytes are delivered, in address order. Each byte equals `bus_din` as it stood in the last clock of its phase-2 access window.
- R6: While `tx_valid` is 1 and `tx_ready` is 0, `tx_valid` and `tx_data` hold. Exactly one bus access window lies between consecutive byte handshakes, and none is started while a byte waits.
- R7: One clock after the handshake of the last byte, `cpu_rdy` is 1 and `tx_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the host bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | One-clock pulse that requests a dump |
| req_base | input | AW | First address of the dump |
| req_len | input | LW | Number of bytes to dump; 0 is ignored |
| phi2 | input | 1 | Host phase-2 level, synchronous to clk |
| cpu_rw | input | 1 | CPU read/write line, 1 = read |
| cpu_rdy | output | 1 | Ready line to the CPU, 0 = hold |
| bus_oe | output | 1 | Block drives address and R/W lines |
| bus_addr | output | AW | Address driven during an access window |
| bus_rw | output | 1 | R/W driven by the block, always read |
| bus_din | input | DW | Data bus as seen by the block |
| tx_data | output | DW | Byte toward the serial transmitter |
| tx_valid | output | 1 | tx_data holds a byte |
| tx_ready | input | 1 | Transmitter accepts the byte |

## Verification
`cpu_rdy` falls one clock after an accepted request. The block moves to its fetch wait at the first read-cycle falling edge of `phi2`. `bus_oe` rises one clock after the following rising edge of `phi2` and falls together with `phi2`. `tx_valid` comes up one clock after `phi2` goes low. `cpu_rdy` returns one clock after the final handshake. The bench drives every input on the falling clock edge. It judges bus-phase events from the values the design saw at the rising edge just passed, and judges handshakes from the values it has just driven, which the next rising edge will take. It sweeps base addresses that include an address wrap, lengths of zero to seven, three transmitter stall patterns, and requests arriving during write cycles, and it compares each byte against an arithmetic memory model.

// File: rtl/dmpc_pkg.sv
package dmpc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_HALT   = 3'd1,
    ST_SLOT   = 3'd2,
    ST_ACCESS = 3'd3,
    ST_SEND   = 3'd4
  } dmpc_state_t;

  function automatic logic edge_fall(input logic prev_lvl, input logic cur_lvl);
    return prev_lvl & ~cur_lvl;
  endfunction

  function automatic logic edge_rise(input logic prev_lvl, input logic cur_lvl);
    return ~prev_lvl & cur_lvl;
  endfunction

endpackage

// File: rtl/dmpc_phase_edge.sv
module dmpc_phase_edge
  import dmpc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic phi2,
  output logic phi2_rise,
  output logic phi2_fall
);

  logic phi2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phi2_q <= 1'b0;
    else        phi2_q <= phi2;
  end

  assign phi2_rise = edge_rise(phi2_q, phi2);
  assign phi2_fall = edge_fall(phi2_q, phi2);

endmodule

// File: rtl/dmpc_cursor.sv
module dmpc_cursor #(
  parameter int AW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  input  logic [LW-1:0] len,
  output logic [AW-1:0] addr,
  output logic          last
);

  logic [LW-1:0] remain;

  function automatic logic [AW-1:0] addr_after(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [LW-1:0] count_after(input logic [LW-1:0] c);
    return c - LW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      remain <= '0;
    end else if (load) begin
      addr   <= base;
      remain <= len;
    end else if (step) begin
      addr   <= addr_after(addr);
      remain <= count_after(remain);
    end
  end

  assign last = (remain == LW'(1));

endmodule

// File: rtl/dmpc_seq.sv
module dmpc_seq
  import dmpc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic        len_nonzero,
  input  logic        phi2,
  input  logic        phi2_rise,
  input  logic        phi2_fall,
  input  logic        cpu_rw,
  input  logic        last,
  input  logic        tx_ready,
  output dmpc_state_t state,
  output logic        load,
  output logic        step,
  output logic        halt_taken
);

  dmpc_state_t nxt;

  always_comb begin
    nxt        = state;
    load       = 1'b0;
    step       = 1'b0;
    halt_taken = 1'b0;
    case (state)
      ST_IDLE: begin
        if (req_start && len_nonzero) begin
          load = 1'b1;
          nxt  = ST_HALT;
        end
      end
      ST_HALT: begin
        if (phi2_fall && cpu_rw) begin
          halt_taken = 1'b1;
          nxt        = ST_SLOT;
        end
      end
      ST_SLOT: begin
        if (phi2_rise) nxt = ST_ACCESS;
      end
      ST_ACCESS: begin
        if (!phi2) nxt = ST_SEND;
      end
      ST_SEND: begin
        if (tx_ready) begin
          if (last) begin
            nxt = ST_IDLE;
          end else begin
            step = 1'b1;
            nxt  = ST_SLOT;
          end
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/halt_dump_ctrl.sv
module halt_dump_ctrl
  import dmpc_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_start,
  input  logic [AW-1:0] req_base,
  input  logic [LW-1:0] req_len,
  input  logic          phi2,
  input  logic          cpu_rw,
  output logic          cpu_rdy,
  output logic          bus_oe,
  output logic [AW-1:0] bus_addr,
  output logic          bus_rw,
  input  logic [DW-1:0] bus_din,
  output logic [DW-1:0] tx_data,
  output logic          tx_valid,
  input  logic          tx_ready
);

  // Named internal events, brought out for the checker.
  logic        phi2_rise;
  logic        phi2_fall;
  logic        halt_taken;
  logic        load;
  logic        step;
  logic        last;
  logic        capture;
  logic        len_nonzero;
  dmpc_state_t state;
  logic [DW-1:0] data_q;

  assign len_nonzero = (req_len != '0);

  dmpc_phase_edge edge_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .phi2      (phi2),
    .phi2_rise (phi2_rise),
    .phi2_fall (phi2_fall)
  );

  dmpc_cursor #(.AW(AW), .LW(LW)) cursor_i (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (load),
    .step  (step),
    .base  (req_base),
    .len   (req_len),
    .addr  (bus_addr),
    .last  (last)
  );

  dmpc_seq seq_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_start   (req_start),
    .len_nonzero (len_nonzero),
    .phi2        (phi2),
    .phi2_rise   (phi2_rise),
    .phi2_fall   (phi2_fall),
    .cpu_rw      (cpu_rw),
    .last        (last),
    .tx_ready    (tx_ready),
    .state       (state),
    .load        (load),
    .step        (step),
    .halt_taken  (halt_taken)
  );

  // The access window is the phase-2 high time inside ST_ACCESS.
  assign capture = (state == ST_ACCESS) && phi2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (capture) data_q <= bus_din;
  end

  assign bus_oe   = capture;
  assign bus_rw   = 1'b1;
  assign cpu_rdy  = (state == ST_IDLE);
  assign tx_valid = (state == ST_SEND);
  assign tx_data  = data_q;

endmodule

// File: rtl/dmpc_checker.sv
module dmpc_checker #(
  parameter int LW = 8,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_start,
  input logic [LW-1:0] req_len,
  input logic          phi2,
  input logic          cpu_rw,
  input logic          cpu_rdy,
  input logic          bus_oe,
  input logic [DW-1:0] tx_data,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          phi2_fall,
  input logic          halt_taken
);

  assert_reset_state_R1: assert property (@(posedge clk)
    !rst_n |=> (cpu_rdy && !tx_valid && !bus_oe));

  assert_start_halts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdy && req_start && req_len != '0) |=> !cpu_rdy);

  assert_zero_len_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rdy && req_start && req_len == '0) |=> cpu_rdy);

  assert_halt_on_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    halt_taken |-> (phi2_fall && cpu_rw && !cpu_rdy));

  assert_access_in_phase2_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (phi2 && !cpu_rdy));

  assert_hold_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  assert_no_fetch_while_waiting_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !bus_oe);

  assert_release_after_last_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rdy) |-> $past(tx_valid && tx_ready));

endmodule

bind halt_dump_ctrl dmpc_checker #(.LW(LW), .DW(DW)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_start  (req_start),
  .req_len    (req_len),
  .phi2       (phi2),
  .cpu_rw     (cpu_rw),
  .cpu_rdy    (cpu_rdy),
  .bus_oe     (bus_oe),
  .tx_data    (tx_data),
  .tx_valid   (tx_valid),
  .tx_ready   (tx_ready),
  .phi2_fall  (phi2_fall),
  .halt_taken (halt_taken)
);

// File: tb/halt_dump_ctrl_tb.sv
module halt_dump_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int LW = 8;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_start = 1'b0;
  logic [AW-1:0] req_base = '0;
  logic [LW-1:0] req_len = '0;
  logic          phi2 = 1'b0;
  logic          cpu_rw = 1'b1;
  logic          cpu_rdy, bus_oe, bus_rw, tx_valid;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_din, tx_data;
  logic          tx_ready = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Memory model: byte at address a.
  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [7:0] lo7;
    lo7 = a[7:0] * 8'd7;
    return lo7 ^ a[15:8] ^ 8'hA5;
  endfunction

  assign bus_din = bus_oe ? mem_byte(bus_addr) : 8'h00;

  halt_dump_ctrl #(.AW(AW), .LW(LW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_base(req_base),
    .req_len(req_len), .phi2(phi2), .cpu_rw(cpu_rw), .cpu_rdy(cpu_rdy),
    .bus_oe(bus_oe), .bus_addr(bus_addr), .bus_rw(bus_rw), .bus_din(bus_din),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready)
  );

  int checks = 0;
  int failures = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // Test control, written by the sequencer only.
  int          launch_id = 0;
  logic [15:0] t_base = '0;
  logic [7:0]  t_len = '0;
  int          t_wr = 0;
  int          t_mode = 0;
  logic        run_en = 1'b0;

  // Bench state, written by the bus process only.
  int          seen_id = 0, done_id = 0;
  int          ph_cnt = 0, wr_left = 0, rdy_cnt = 0, cyc = 0;
  int          bytes = 0, c_len = 0, acc_since = 0;
  logic [15:0] c_base = '0;
  logic        prev_phi2 = 1'b0, prev_oe = 1'b0;
  logic        active = 1'b0, finishing = 1'b0;
  logic        armed = 1'b0, arm_delay = 1'b0, halt_ok = 1'b0;
  logic        hold_pending = 1'b0;
  logic [7:0]  hold_data = '0;
  logic        wd_fired = 1'b0;

  always @(negedge clk) begin
    if (run_en) begin
      cyc++;
      // Part 1: values the design took at the rising edge just passed.
      if (arm_delay) begin
        arm_delay = 1'b0;
        armed     = 1'b1;
      end else if (armed && prev_phi2 && !phi2 && cpu_rw) begin
        halt_ok = 1'b1;
        armed   = 1'b0;
      end
      if (hold_pending) begin
        check(tx_valid && tx_data == hold_data, "R6 byte held while stalled",
              int'(tx_data), int'(hold_data));
        hold_pending = 1'b0;
      end
      if (bus_oe) begin
        check(halt_ok, "R3 access only after read-cycle halt", 0, 1);
        check(phi2, "R4 access inside phase 2", int'(phi2), 1);
        check(bus_addr == c_base + 16'(bytes), "R4 access address",
              int'(bus_addr), int'(c_base + 16'(bytes)));
        check(bus_rw, "R4 block reads", int'(bus_rw), 1);
      end
      if (bus_oe && !prev_oe) acc_since++;
      prev_oe = bus_oe;
      if (finishing) begin
        check(cpu_rdy && !tx_valid, "R7 release after last byte",
              int'({cpu_rdy, tx_valid}), 2);
        finishing = 1'b0;
        active    = 1'b0;
        done_id   = seen_id;
      end else if (active) begin
        check(!cpu_rdy, "R2 cpu held during dump", int'(cpu_rdy), 0);
      end else begin
        check(cpu_rdy && !tx_valid && !bus_oe, "R2 idle outputs",
              int'({cpu_rdy, tx_valid, bus_oe}), 4);
      end
      prev_phi2 = phi2;

      // Part 2: drive inputs for the next rising edge.
      ph_cnt++;
      phi2 = ((ph_cnt % 8) >= 4);
      if ((ph_cnt % 8) == 1) begin
        if (wr_left > 0) begin
          cpu_rw = 1'b0;
          wr_left--;
        end else begin
          cpu_rw = 1'b1;
        end
      end
      rdy_cnt++;
      case (t_mode)
        0:       tx_ready = 1'b1;
        1:       tx_ready = ((rdy_cnt % 3) == 0);
        default: tx_ready = ((rdy_cnt % 5) >= 2);
      endcase
      if (launch_id != seen_id) begin
        seen_id   = launch_id;
        req_start = 1'b1;
        req_base  = t_base;
        req_len   = t_len;
        c_base    = t_base;
        c_len     = int'(t_len);
        bytes     = 0;
        acc_since = 0;
        arm_delay = 1'b1;
        armed     = 1'b0;
        halt_ok   = 1'b0;
        if (t_wr > 0) begin
          cpu_rw  = 1'b0;
          wr_left = t_wr - 1;
        end
        active = (t_len != 8'd0);
        if (t_len == 8'd0) done_id = seen_id;
      end else begin
        req_start = 1'b0;
      end

      // Part 3: handshake the next rising edge will take.
      if (tx_valid && tx_ready) begin
        check(tx_data == mem_byte(c_base + 16'(bytes)), "R5 byte value",
              int'(tx_data), int'(mem_byte(c_base + 16'(bytes))));
        check(acc_since == 1, "R6 one access per byte", acc_since, 1);
        acc_since = 0;
        bytes++;
        if (bytes >= c_len) begin
          check(bytes == c_len, "R5 byte count", bytes, c_len);
          finishing = 1'b1;
        end
      end else if (tx_valid) begin
        hold_pending = 1'b1;
        hold_data    = tx_data;
      end

      if (cyc > 150000 && !wd_fired) begin
        wd_fired = 1'b1;
        failures++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    check(cpu_rdy && !tx_valid && !bus_oe, "R1 state in reset",
          int'({cpu_rdy, tx_valid, bus_oe}), 4);
    rst_n = 1'b1;
    @(negedge clk);
    check(cpu_rdy && !tx_valid && !bus_oe, "R1 state after reset",
          int'({cpu_rdy, tx_valid, bus_oe}), 4);
    run_en = 1'b1;
    for (int bi = 0; bi < 4; bi++) begin
      for (int li = 0; li < 4; li++) begin
        for (int mi = 0; mi < 3; mi++) begin
          for (int wi = 0; wi < 2; wi++) begin
            @(posedge clk);
            case (bi)
              0:       t_base = 16'h0000;
              1:       t_base = 16'h1234;
              2:       t_base = 16'hFFFD;
              default: t_base = 16'h80FF;
            endcase
            case (li)
              0:       t_len = 8'd0;
              1:       t_len = 8'd1;
              2:       t_len = 8'd3;
              default: t_len = 8'd7;
            endcase
            t_mode = mi;
            t_wr   = wi * 2;
            launch_id++;
            while (done_id != launch_id) @(posedge clk);
            repeat (12) @(posedge clk);
          end
        end
      end
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule